// File: doc/BRIEF.md
# Ethernet Header Parser and Classification Key Builder

This block sits at the front of a packet classification pipeline. It takes in a frame as a stream of 8-byte beats, captures the leading bytes of the frame into a small header window, and from that window works out how many IEEE 802.1Q tags precede the inner EtherType: none, one or two. It then builds a fixed 264-bit lookup key. The key carries the frame's plugin tag and ingress port, the outer tag's priority and VLAN, both MAC addresses, the inner EtherType and the first 16 bytes of the layer-3 payload. The same L2 fields also leave the block on their own ports.

A frame is handed in beat by beat with a valid/ready handshake and ends on the beat marked last. Each beat is treated as carrying 8 full bytes. Once the last beat is in, the key is offered with its own valid/ready handshake. No further beat is accepted until the key has been taken. Bytes after the header window are consumed and dropped. The block does no lookup, no CRC check and no rewriting of the frame.

Top module: `eth_key_builder`

## Requirements
- R1: An untagged frame (bytes 12..13 not equal to 0x8100) gives EtherType from bytes 12..13, layer-3 data from byte 14 onward, VLAN and priority both zero, and the untagged flag set to 1.
- R2: A single-tagged frame has 0x8100 at bytes 12..13. For it, priority is byte 14 bits 7..4, VLAN is {byte 14 bits 3..0, byte 15}, EtherType comes from bytes 16..17, layer-3 data starts at byte 18, and the untagged flag is 0.
- R3: A double-tagged frame has 0x8100 at bytes 12..13 and again at bytes 16..17. For it, priority and VLAN come from the outer tag (bytes 14..15), EtherType comes from bytes 20..21 and layer-3 data starts at byte 22. A third 0x8100 at bytes 20..21 is reported as the EtherType. Only the type value 0x8100 marks a tag.
- R4: The key is packed from bit 263 down as: plugin tag (5 bits), ingress port (3), priority (4), VLAN (12), destination MAC (48), source MAC (48), EtherType (16), then 16 layer-3 bytes with the earliest byte in bits 127..120.
- R5: The destination MAC is frame bytes 0..5 and the source MAC is bytes 6..11, each with the first byte as the most significant.
- R6: Byte n of beat k (n = 0..7) is frame byte 8k+n and sits in in_data bits 63-8n down to 56-8n. Any key byte that lies past the end of the frame reads as zero.
- R7: Frames of any beat count are fully consumed. Bytes beyond byte 39 have no effect on the key.
- R8: key_valid rises in the cycle after the last beat is accepted. While key_valid is high, in_ready is low. The key and the field outputs stay stable until the cycle in which key_ready is seen high. After that cycle key_valid is low and in_ready is high.
- R9: The plugin tag and ingress port are taken from the first beat of the frame. Values on those inputs during later beats have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on in_data |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 64 | Frame beat, earliest byte in bits 63..56 |
| in_last | input | 1 | Beat is the final one of the frame |
| in_tag | input | 5 | Plugin tag, sampled on the first beat |
| in_port | input | 3 | Ingress port, sampled on the first beat |
| key_valid | output | 1 | Key and fields are valid |
| key_ready | input | 1 | Consumer takes the key |
| key_o | output | 264 | Classification key |
| dst_mac | output | 48 | Destination MAC |
| src_mac | output | 48 | Source MAC |
| vlan_id | output | 12 | VLAN of the outer tag, zero if untagged |
| vlan_prio | output | 4 | Priority bits of the outer tag, zero if untagged |
| ether_type | output | 16 | Inner EtherType |
| untagged | output | 1 | Frame carried no 802.1Q tag |

## Verification
The assertions assume that the producer marks every frame's final beat with in_last. They also assume that a rising key_valid can only follow an accepted last beat, and that the consumer may hold key_ready low for any number of cycles. The stimulus keeps to this. It drives frames of 1 to 8 beats, each ending with in_last, with random idle gaps between beats and random stalls before key_ready. During those stalls it deliberately drives stray valid beats, which the block must not accept. Random tag counts cover all three parse paths. Short frames land the layer-3 window past the end of the frame, long frames carry marker bytes beyond the header window, and the plugin tag and port are changed on later beats.

// File: rtl/eth_kb_pkg.sv
package eth_kb_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int TAG_W      = 5;
    localparam int PORT_W     = 3;
    localparam int PRIO_W     = 4;
    localparam int VID_W      = 12;
    localparam int MAC_W      = 48;
    localparam int ETYPE_W    = 16;
    localparam int L3_BYTES   = 16;
    localparam int MAX_TAGS   = 2;
    localparam int L2_BASE    = 14;
    localparam int TAG_BYTES  = 4;
    localparam logic [15:0] VLAN_TPID = 16'h8100;
    localparam int NEED_BYTES = L2_BASE + MAX_TAGS * TAG_BYTES + L3_BYTES;
    localparam int WIN_BEATS  = (NEED_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
    localparam int KEY_W      = TAG_W + PORT_W + PRIO_W + VID_W + 2 * MAC_W
                              + ETYPE_W + L3_BYTES * 8;

    typedef struct packed {
        logic [PRIO_W-1:0]  prio;
        logic [VID_W-1:0]   vid;
        logic [MAC_W-1:0]   dmac;
        logic [MAC_W-1:0]   smac;
        logic [ETYPE_W-1:0] etype;
        logic               no_tag;
    } l2_fields_t;
endpackage

// File: rtl/eth_kb_window.sv
module eth_kb_window
    import eth_kb_pkg::*;
#(
    parameter int BEATS  = WIN_BEATS,
    parameter int BBYTES = BEAT_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BBYTES*8-1:0]     in_data,
    input  logic                    in_last,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic [PORT_W-1:0]       in_port,
    input  logic                    key_ready,
    output logic                    in_ready,
    output logic                    pending,
    output logic [BEATS*BBYTES*8-1:0] win,
    output logic [TAG_W-1:0]        tag,
    output logic [PORT_W-1:0]       port
);
    localparam int BEAT_BITS = BBYTES * 8;
    localparam int WIN_BITS  = BEATS * BEAT_BITS;
    localparam int CNT_W     = $clog2(BEATS + 1);

    typedef struct packed {
        logic [WIN_BITS-1:0] win;
        logic [CNT_W-1:0]    cnt;
        logic                first;
        logic                done;
        logic [TAG_W-1:0]    tag;
        logic [PORT_W-1:0]   port;
    } win_st_t;

    win_st_t s_d, s_q;
    logic    acc, take;

    always_comb begin
        s_d  = s_q;
        acc  = in_valid && !s_q.done;
        take = s_q.done && key_ready;
        if (take) begin
            s_d       = '0;
            s_d.first = 1'b1;
        end else if (acc) begin
            if (s_q.first) begin
                s_d.tag   = in_tag;
                s_d.port  = in_port;
                s_d.first = 1'b0;
            end
            for (int k = 0; k < BEATS; k++) begin
                if (s_q.cnt == CNT_W'(k)) begin
                    s_d.win[WIN_BITS-1-k*BEAT_BITS -: BEAT_BITS] = in_data;
                    s_d.cnt = CNT_W'(k + 1);
                end
            end
            if (in_last) s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.done;
    assign pending  = s_q.done;
    assign win      = s_q.win;
    assign tag      = s_q.tag;
    assign port     = s_q.port;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(BEATS))
        else $error("beat counter past window");
endmodule

// File: rtl/eth_kb_extract.sv
module eth_kb_extract
    import eth_kb_pkg::*;
#(
    parameter int WBYTES = WIN_BEATS * BEAT_BYTES,
    parameter int LBYTES = L3_BYTES
) (
    input  logic [WBYTES*8-1:0] win,
    output l2_fields_t          fields,
    output logic [LBYTES*8-1:0] l3
);
    localparam int WIN_BITS = WBYTES * 8;
    localparam int OFS1     = L2_BASE + TAG_BYTES;
    localparam int OFS2     = L2_BASE + 2 * TAG_BYTES;

    logic [7:0] b [WBYTES];
    logic       tag1, tag2;
    logic [15:0] tci;

    for (genvar i = 0; i < WBYTES; i++) begin : g_bytes
        assign b[i] = win[WIN_BITS-1-8*i -: 8];
    end

    assign tag1 = {b[12], b[13]} == VLAN_TPID;
    assign tag2 = tag1 && ({b[16], b[17]} == VLAN_TPID);
    assign tci  = tag1 ? {b[14], b[15]} : 16'h0;

    always_comb begin
        fields.dmac   = {b[0], b[1], b[2], b[3], b[4], b[5]};
        fields.smac   = {b[6], b[7], b[8], b[9], b[10], b[11]};
        fields.prio   = tci[15:12];
        fields.vid    = tci[11:0];
        fields.no_tag = !tag1;
        if (tag2)      fields.etype = {b[OFS2-2], b[OFS2-1]};
        else if (tag1) fields.etype = {b[OFS1-2], b[OFS1-1]};
        else           fields.etype = {b[L2_BASE-2], b[L2_BASE-1]};
    end

    for (genvar j = 0; j < LBYTES; j++) begin : g_l3
        assign l3[LBYTES*8-1-8*j -: 8] = tag2 ? b[OFS2+j] :
                                         tag1 ? b[OFS1+j] : b[L2_BASE+j];
    end
endmodule

// File: rtl/eth_key_builder.sv
module eth_key_builder
    import eth_kb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [63:0]           in_data,
    input  logic                  in_last,
    input  logic [4:0]            in_tag,
    input  logic [2:0]            in_port,
    output logic                  key_valid,
    input  logic                  key_ready,
    output logic [263:0]          key_o,
    output logic [47:0]           dst_mac,
    output logic [47:0]           src_mac,
    output logic [11:0]           vlan_id,
    output logic [3:0]            vlan_prio,
    output logic [15:0]           ether_type,
    output logic                  untagged
);
    localparam int WBYTES = WIN_BEATS * BEAT_BYTES;

    logic [WBYTES*8-1:0]   win;
    logic [TAG_W-1:0]      tag;
    logic [PORT_W-1:0]     port;
    l2_fields_t            fields;
    logic [L3_BYTES*8-1:0] l3;

    eth_kb_window #(.BEATS(WIN_BEATS), .BBYTES(BEAT_BYTES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_tag   (in_tag),
        .in_port  (in_port),
        .key_ready(key_ready),
        .in_ready (in_ready),
        .pending  (key_valid),
        .win      (win),
        .tag      (tag),
        .port     (port)
    );

    eth_kb_extract #(.WBYTES(WBYTES), .LBYTES(L3_BYTES)) u_ext (
        .win   (win),
        .fields(fields),
        .l3    (l3)
    );

    assign key_o = {tag, port, fields.prio, fields.vid, fields.dmac,
                    fields.smac, fields.etype, l3};
    assign dst_mac    = fields.dmac;
    assign src_mac    = fields.smac;
    assign vlan_id    = fields.vid;
    assign vlan_prio  = fields.prio;
    assign ether_type = fields.etype;
    assign untagged   = fields.no_tag;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && !key_ready |=> key_valid && $stable(key_o))
        else $error("key changed while pending");
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> !in_ready)
        else $error("input open while key pending");
    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> $past(in_valid && in_last))
        else $error("key without a last beat");
    p_untag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && untagged |-> key_o[255:240] == 16'h0)
        else $error("untagged frame with nonzero tag fields");
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && key_ready |=> !key_valid && in_ready)
        else $error("key not released");
endmodule

// File: tb/eth_key_builder_tb.sv
module eth_key_builder_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_ready, in_last, key_valid, key_ready, untagged;
    logic [63:0]  in_data;
    logic [4:0]   in_tag;
    logic [2:0]   in_port;
    logic [263:0] key_o;
    logic [47:0]  dst_mac, src_mac;
    logic [11:0]  vlan_id;
    logic [3:0]   vlan_prio;
    logic [15:0]  ether_type;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] frm [64];
    int nbytes;

    always #5 clk = ~clk;

    eth_key_builder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_tag(in_tag), .in_port(in_port),
        .key_valid(key_valid), .key_ready(key_ready), .key_o(key_o),
        .dst_mac(dst_mac), .src_mac(src_mac), .vlan_id(vlan_id),
        .vlan_prio(vlan_prio), .ether_type(ether_type), .untagged(untagged)
    );

    task automatic chk(input bit ok, input string req, input logic [263:0] act,
                       input logic [263:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] g(input int i);
        return (i < nbytes && i < 64) ? frm[i] : 8'h00;
    endfunction

    function automatic int exp_tags();
        int n = 0;
        if ({g(12), g(13)} == 16'h8100) begin
            n = 1;
            if ({g(16), g(17)} == 16'h8100) n = 2;
        end
        return n;
    endfunction

    function automatic logic [263:0] exp_key(input logic [4:0] t, input logic [2:0] p);
        int n = exp_tags();
        logic [15:0] tci = (n > 0) ? {g(14), g(15)} : 16'h0;
        logic [127:0] l3;
        for (int j = 0; j < 16; j++) l3[127-8*j -: 8] = g(14 + 4*n + j);
        return {t, p, tci, g(0), g(1), g(2), g(3), g(4), g(5),
                g(6), g(7), g(8), g(9), g(10), g(11),
                g(12 + 4*n), g(13 + 4*n), l3};
    endfunction

    // fill frm with random bytes and force the requested tag count
    task automatic build(input int ntags, input int beats);
        nbytes = beats * 8;
        for (int i = 0; i < 64; i++) frm[i] = 8'($urandom);
        if (ntags >= 1) begin frm[12] = 8'h81; frm[13] = 8'h00; end
        else if (frm[12] == 8'h81) frm[12] = 8'h08;
        if (ntags == 2) begin frm[16] = 8'h81; frm[17] = 8'h00; end
        else if (frm[16] == 8'h81) frm[16] = 8'h86;
    endtask

    task automatic run_frame(input int beats, input string rq);
        logic [4:0] t = 5'($urandom);
        logic [2:0] p = 3'($urandom);
        logic [263:0] ek, held;
        int n;
        for (int b = 0; b < beats; b++) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            chk(in_ready === 1'b1, "R8 ready during frame", 264'(in_ready), 264'(1));
            in_valid = 1'b1;
            in_last  = (b == beats - 1);
            for (int k = 0; k < 8; k++) in_data[63-8*k -: 8] = g(8*b + k);
            in_tag  = (b == 0) ? t : 5'($urandom);
            in_port = (b == 0) ? p : 3'($urandom);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        ek = exp_key(t, p);
        n  = exp_tags();
        chk(key_valid === 1'b1, "R8 key_valid after last", 264'(key_valid), 264'(1));
        chk(in_ready === 1'b0, "R8 in_ready low while pending", 264'(in_ready), 264'(0));
        chk(key_o === ek, {rq, " R4 R6 R7 R9 key"}, key_o, ek);
        chk({dst_mac, src_mac} === ek[239:144], "R5 MACs", 264'({dst_mac, src_mac}),
            264'(ek[239:144]));
        chk(ether_type === ek[143:128], {rq, " EtherType"}, 264'(ether_type), 264'(ek[143:128]));
        chk({vlan_prio, vlan_id} === ek[255:240], {rq, " priority/VLAN"},
            264'({vlan_prio, vlan_id}), 264'(ek[255:240]));
        chk(untagged === (n == 0), {rq, " untagged flag"}, 264'(untagged), 264'(n == 0));
        held = key_o;
        repeat ($urandom_range(0, 3)) begin
            in_valid = 1'b1;
            in_last  = 1'b1;
            in_data  = {$urandom, $urandom};
            @(negedge clk);
            chk(key_valid === 1'b1 && key_o === held, "R8 key held", key_o, held);
        end
        in_valid  = 1'b0;
        in_last   = 1'b0;
        key_ready = 1'b1;
        @(negedge clk);
        key_ready = 1'b0;
        chk(key_valid === 1'b0 && in_ready === 1'b1, "R8 release",
            264'({key_valid, in_ready}), 264'(2'b01));
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; key_ready = 1'b0;
        in_data = '0; in_tag = '0; in_port = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(key_valid === 1'b0 && in_ready === 1'b1, "R8 reset state",
            264'({key_valid, in_ready}), 264'(2'b01));

        // R1: one-beat untagged frame, L3 and EtherType past the end read zero
        build(0, 1); run_frame(1, "R1 R6 short");
        // R3: three-beat double-tagged frame, L3 almost all padding
        build(2, 3); run_frame(3, "R3 R6 short");
        // R3: third 0x8100 after two tags is the EtherType
        build(2, 6); frm[20] = 8'h81; frm[21] = 8'h00; run_frame(6, "R3 third tpid");
        // R3: outer 0x88a8 is not a tag
        build(0, 5); frm[12] = 8'h88; frm[13] = 8'ha8; run_frame(5, "R3 other tpid");
        // R7: long frame, bytes past 39 all ones
        build(1, 8); for (int i = 40; i < 64; i++) frm[i] = 8'hff; run_frame(8, "R2 R7 long");
        // R2: minimal single-tag frame exactly filling window
        build(1, 5); run_frame(5, "R2 window");

        for (int f = 0; f < 60; f++) begin
            int nt = $urandom_range(0, 2);
            int bt = $urandom_range(1, 8);
            build(nt, bt);
            run_frame(bt, nt == 0 ? "R1 rand" : (nt == 1 ? "R2 rand" : "R3 rand"));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule